// File: doc/BRIEF.md
# Shared Accelerator Context Shell with State Save and Restore

This block hosts four small accelerator functions behind one fixed boundary, so that the surrounding system always sees the same signals whichever function is active. Software drives it through a small register-mapped bus slave: it programs a sample count and two base addresses, selects a function and starts a run. The shell streams samples from an input data RAM through its read port, passes them through the selected function and writes the results through the write port of an output data RAM. Only the selected function reaches the shared RAM and bus signals. A multiplexer picks its output and holds the others at zero.

Two of the functions keep internal state between samples: a running-sum filter stand-in and a halving-accumulator estimator stand-in. Switching to a different function is treated as a context swap, and a swap wipes all hosted state. Before a swap, software can copy the loaded function's state into a dedicated state memory. Later it can load that state back, so a run that was interrupted produces exactly the samples an uninterrupted run would have produced. The other two functions, a bias combiner and a key correlator, keep no state.

Top module: `accel_ctx_shell`

## Requirements
- R1: After synchronous reset, the status register reads 0, all configuration registers read 0, the loaded function is 0 and both RAM enables are low.
- R2: Register addresses: 0 command (write bit0 = start, bits[3:2] = function), 1 sample count (11 bits, read back), 2 source base (10 bits, read back), 3 destination base (10 bits, read back), 4 save/restore request (bit0 = save, bit1 = restore, bits[3:2] = function), 5 status. Reads return data in the cycle after the read strobe.
- R3: A run reads input addresses src, src+1, ... and writes the result of sample i to dst+i. The first output write enable is high in the third cycle after the edge that accepts the start. The done status bit is set at the edge that registers the last write, and the input write enable is never asserted.
- R4: The stateless functions compute combiner (function 1) y = x + 0x0101 and correlator (function 2) y = x XOR 0x5A5A, all modulo 2^16.
- R5: Filter (function 0) computes acc = acc + x and y = acc + prev, then prev = x. Estimator (function 3) computes acc = acc + (x >> 1) and y = acc - prev, then prev = x. The state carries over between runs of the same function.
- R6: Starting or restoring a function different from the loaded one is a swap: all hosted state is cleared and that function becomes the loaded one.
- R7: A save of the loaded stateful function copies its state words into its slot of the state memory and sets the save-complete status bit.
- R8: A restore of a stateful function loads its saved state words (after a swap if needed) and sets the restore-complete status bit. Output after save, swap and restore equals an uninterrupted run.
- R9: Each accepted run produces exactly count output writes, all from the selected function, with write enable equal to enable.
- R10: A start, save or restore issued while a run or save/restore is in progress, or a start with count 0, is refused. It sets the error bit and has no other effect.
- R11: A save or restore naming a stateless function, or a save naming a function other than the loaded one, is refused and sets the error bit.
- R12: Status bits: [0] busy, [1] done, [2] save-complete, [3] restore-complete, [4] error, [6:5] loaded function. Any write to the status address clears bits 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Bus slave select |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| in_en | output | 1 | Input RAM enable |
| in_we | output | 1 | Input RAM write enable (held low) |
| in_addr | output | 10 | Input RAM address |
| in_rdata | input | 16 | Input RAM read data, one cycle after enable |
| out_en | output | 1 | Output RAM enable |
| out_we | output | 1 | Output RAM write enable |
| out_addr | output | 10 | Output RAM address |
| out_wdata | output | 16 | Output RAM write data |

## Verification
Register reads are sampled in the cycle after the read strobe. The first output write is checked at exactly the third falling edge after the command write is accepted: one cycle to issue the read, one for the RAM, one for the output register. Results in the output RAM, the write counts and the status bits are checked only once polling shows busy low. At that point the done bit, which is set with the last write, must already be visible. Refused requests are checked after completion through the error bit, the write count and a later restore-and-run whose samples show whether the saved state was left untouched.

// File: rtl/accel_ctx_pkg.sv
package accel_ctx_pkg;
  localparam int KIND_FILT = 0;
  localparam int KIND_COMB = 1;
  localparam int KIND_CORR = 2;
  localparam int KIND_EST  = 3;

  localparam logic [3:0] REG_CMD    = 4'h0;
  localparam logic [3:0] REG_LEN    = 4'h1;
  localparam logic [3:0] REG_SRC    = 4'h2;
  localparam logic [3:0] REG_DST    = 4'h3;
  localparam logic [3:0] REG_SRREQ  = 4'h4;
  localparam logic [3:0] REG_STATUS = 4'h5;

  localparam logic [15:0] COMB_BIAS = 16'h0101;
  localparam logic [15:0] CORR_KEY  = 16'h5A5A;

  function automatic bit kind_stateful(input int kind);
    return (kind == KIND_FILT) || (kind == KIND_EST);
  endfunction
endpackage

// File: rtl/ctx_bus_regs.sv
module ctx_bus_regs
  import accel_ctx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW   = 10,
  parameter int RAW  = 4,
  parameter int FN_W = 2,
  parameter int LW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_cs,
  input  logic [RAW-1:0]  bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            bus_wr,
  input  logic            bus_rd,
  output logic [DW-1:0]   bus_rdata,
  input  logic            busy,
  input  logic [FN_W-1:0] loaded_fn,
  input  logic            set_done,
  input  logic            set_sv,
  input  logic            set_rs,
  input  logic            set_err,
  output logic            start_req,
  output logic            save_req,
  output logic            restore_req,
  output logic [FN_W-1:0] req_fn,
  output logic [LW-1:0]   len_q,
  output logic [AW-1:0]   src_q,
  output logic [AW-1:0]   dst_q
);
  logic            wr_hit, clr_sticky;
  logic [FN_W-1:0] cmd_fn_q, sr_fn_q;
  logic            done_q, sv_q, rs_q, err_q;
  logic            unused_hi;

  assign wr_hit      = bus_cs && bus_wr;
  assign req_fn      = bus_wdata[2 +: FN_W];
  assign start_req   = wr_hit && (bus_addr == RAW'(REG_CMD)) && bus_wdata[0];
  assign save_req    = wr_hit && (bus_addr == RAW'(REG_SRREQ)) && bus_wdata[0];
  assign restore_req = wr_hit && (bus_addr == RAW'(REG_SRREQ)) && bus_wdata[1];
  assign clr_sticky  = wr_hit && (bus_addr == RAW'(REG_STATUS));
  assign unused_hi   = ^bus_wdata[DW-1:LW];

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      cmd_fn_q <= '0;
      sr_fn_q  <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        RAW'(REG_CMD):   cmd_fn_q <= req_fn;
        RAW'(REG_LEN):   len_q    <= bus_wdata[LW-1:0];
        RAW'(REG_SRC):   src_q    <= bus_wdata[AW-1:0];
        RAW'(REG_DST):   dst_q    <= bus_wdata[AW-1:0];
        RAW'(REG_SRREQ): sr_fn_q  <= req_fn;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      sv_q   <= 1'b0;
      rs_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= set_done || (done_q && !clr_sticky);
      sv_q   <= set_sv   || (sv_q   && !clr_sticky);
      rs_q   <= set_rs   || (rs_q   && !clr_sticky);
      err_q  <= set_err  || (err_q  && !clr_sticky);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_cs && bus_rd) begin
      case (bus_addr)
        RAW'(REG_CMD):    bus_rdata <= DW'({cmd_fn_q, 2'b00});
        RAW'(REG_LEN):    bus_rdata <= DW'(len_q);
        RAW'(REG_SRC):    bus_rdata <= DW'(src_q);
        RAW'(REG_DST):    bus_rdata <= DW'(dst_q);
        RAW'(REG_SRREQ):  bus_rdata <= DW'({sr_fn_q, 2'b00});
        RAW'(REG_STATUS): bus_rdata <= DW'({loaded_fn, err_q, rs_q, sv_q, done_q, busy});
        default:          bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ctx_fn_slot.sv
module ctx_fn_slot
  import accel_ctx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int KIND = 0,
  parameter int SW   = 2,
  parameter int IW   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          sel,
  input  logic          in_valid,
  input  logic [DW-1:0] x,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic [IW-1:0] st_idx,
  output logic [DW-1:0] st_data,
  output logic [DW-1:0] y,
  output logic          y_valid
);
  assign y_valid = in_valid && sel;

  generate
    if (kind_stateful(KIND)) begin : g_stateful
      logic [DW-1:0] st_q [SW];
      logic [DW-1:0] acc_n;

      always_comb begin
        if (KIND == KIND_FILT) begin
          acc_n = st_q[0] + x;
          y     = acc_n + st_q[1];
        end else begin
          acc_n = st_q[0] + (x >> 1);
          y     = acc_n - st_q[1];
        end
      end

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          for (int i = 0; i < SW; i++) st_q[i] <= '0;
        end else if (ld_en) begin
          st_q[ld_idx] <= ld_data;
        end else if (y_valid) begin
          st_q[0] <= acc_n;
          st_q[1] <= x;
        end
      end

      assign st_data = st_q[st_idx];
    end else begin : g_stateless
      logic unused_sl;
      assign unused_sl = ^{clk, rst, clr, ld_en, ld_idx, ld_data, st_idx};
      assign st_data   = '0;
      assign y = (KIND == KIND_COMB) ? (x + DW'(COMB_BIAS)) : (x ^ DW'(CORR_KEY));
    end
  endgenerate
endmodule

// File: rtl/ctx_state_ram.sv
module ctx_state_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int MAW   = 3
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [MAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ctx_sr_seq.sv
module ctx_sr_seq #(
  parameter int DW   = 16,
  parameter int FN_W = 2,
  parameter int SW   = 2,
  parameter int IW   = 1,
  parameter int MAW  = 3,
  parameter int CW   = $clog2(SW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save_go,
  input  logic            restore_go,
  input  logic [FN_W-1:0] fn_in,
  output logic            busy,
  output logic [FN_W-1:0] tgt_fn,
  output logic [IW-1:0]   st_idx,
  input  logic [DW-1:0]   st_data,
  output logic            mem_we,
  output logic [MAW-1:0]  mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_re,
  output logic [MAW-1:0]  mem_raddr,
  input  logic [DW-1:0]   mem_rdata,
  output logic            ld_en,
  output logic [IW-1:0]   ld_idx,
  output logic [DW-1:0]   ld_data,
  output logic            save_done,
  output logic            restore_done
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_SAVE, SQ_LOAD} sq_e;

  sq_e            state_q;
  logic [CW-1:0]  cnt_q, iss_q;
  logic           pend_q;
  logic [IW-1:0]  pidx_q;
  logic [MAW-1:0] base;

  assign busy         = (state_q != SQ_IDLE);
  assign base         = MAW'(tgt_fn) * MAW'(SW);
  assign st_idx       = cnt_q[IW-1:0];
  assign mem_we       = (state_q == SQ_SAVE);
  assign mem_waddr    = base + MAW'(cnt_q);
  assign mem_wdata    = st_data;
  assign mem_re       = (state_q == SQ_LOAD) && (iss_q < CW'(SW));
  assign mem_raddr    = base + MAW'(iss_q);
  assign ld_en        = pend_q;
  assign ld_idx       = pidx_q;
  assign ld_data      = mem_rdata;
  assign save_done    = mem_we && (cnt_q == CW'(SW - 1));
  assign restore_done = ld_en && (pidx_q == IW'(SW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SQ_IDLE;
      tgt_fn  <= '0;
      cnt_q   <= '0;
      iss_q   <= '0;
      pend_q  <= 1'b0;
      pidx_q  <= '0;
    end else begin
      pend_q <= mem_re;
      pidx_q <= iss_q[IW-1:0];
      case (state_q)
        SQ_IDLE: begin
          if (save_go) begin
            state_q <= SQ_SAVE;
            tgt_fn  <= fn_in;
            cnt_q   <= '0;
          end else if (restore_go) begin
            state_q <= SQ_LOAD;
            tgt_fn  <= fn_in;
            iss_q   <= '0;
          end
        end
        SQ_SAVE: begin
          cnt_q <= cnt_q + CW'(1);
          if (save_done) state_q <= SQ_IDLE;
        end
        SQ_LOAD: begin
          if (mem_re) iss_q <= iss_q + CW'(1);
          if (restore_done) state_q <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/accel_ctx_shell.sv
module accel_ctx_shell
  import accel_ctx_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 10,
  parameter int RAW    = 4,
  parameter int NUM_FN = 4,
  parameter int SW     = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_cs,
  input  logic [RAW-1:0] bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic           bus_wr,
  input  logic           bus_rd,
  output logic [DW-1:0]  bus_rdata,
  output logic           in_en,
  output logic           in_we,
  output logic [AW-1:0]  in_addr,
  input  logic [DW-1:0]  in_rdata,
  output logic           out_en,
  output logic           out_we,
  output logic [AW-1:0]  out_addr,
  output logic [DW-1:0]  out_wdata
);
  localparam int FN_W  = $clog2(NUM_FN);
  localparam int LW    = AW + 1;
  localparam int IW    = (SW > 1) ? $clog2(SW) : 1;
  localparam int DEPTH = NUM_FN * SW;
  localparam int MAW   = $clog2(DEPTH);

  logic            start_req, save_req, restore_req;
  logic [FN_W-1:0] req_fn, loaded_q, run_fn;
  logic [LW-1:0]   len_q, rd_cnt, wr_cnt;
  logic [AW-1:0]   src_q, dst_q;
  logic            run_on, v1, run_done, busy;
  logic            start_ok, save_ok, rest_ok, set_err, req_stateful, swap_clr;
  logic            sr_busy, sr_ld_en, save_done, restore_done;
  logic [FN_W-1:0] sr_tgt;
  logic [IW-1:0]   sr_st_idx, sr_ld_idx;
  logic [DW-1:0]   sr_st_data, sr_ld_data;
  logic            m_we, m_re;
  logic [MAW-1:0]  m_waddr, m_raddr;
  logic [DW-1:0]   m_wdata, m_rdata;
  logic [DW-1:0]   slot_y [NUM_FN];
  logic [DW-1:0]   slot_st [NUM_FN];
  logic [DW-1:0]   gated_y [NUM_FN];
  logic [NUM_FN-1:0] slot_v;
  logic [DW-1:0]   mux_y;
  logic            mux_valid;

  assign in_we        = 1'b0;
  assign busy         = run_on || sr_busy;
  assign req_stateful = kind_stateful(int'(req_fn) % 4);
  assign start_ok     = start_req && !busy && (len_q != '0);
  assign save_ok      = save_req && !restore_req && !busy && req_stateful && (req_fn == loaded_q);
  assign rest_ok      = restore_req && !save_req && !busy && req_stateful;
  assign set_err      = (start_req && !start_ok) || (save_req && !save_ok) ||
                        (restore_req && !rest_ok);
  assign swap_clr     = (start_ok || rest_ok) && (req_fn != loaded_q);
  assign run_done     = mux_valid && (wr_cnt == len_q - LW'(1));

  ctx_bus_regs #(.DW(DW), .AW(AW), .RAW(RAW), .FN_W(FN_W), .LW(LW)) u_regs (
    .clk, .rst, .bus_cs, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
    .busy, .loaded_fn(loaded_q), .set_done(run_done), .set_sv(save_done),
    .set_rs(restore_done), .set_err, .start_req, .save_req, .restore_req,
    .req_fn, .len_q, .src_q, .dst_q
  );

  ctx_sr_seq #(.DW(DW), .FN_W(FN_W), .SW(SW), .IW(IW), .MAW(MAW)) u_seq (
    .clk, .rst, .save_go(save_ok), .restore_go(rest_ok), .fn_in(req_fn),
    .busy(sr_busy), .tgt_fn(sr_tgt), .st_idx(sr_st_idx), .st_data(sr_st_data),
    .mem_we(m_we), .mem_waddr(m_waddr), .mem_wdata(m_wdata),
    .mem_re(m_re), .mem_raddr(m_raddr), .mem_rdata(m_rdata),
    .ld_en(sr_ld_en), .ld_idx(sr_ld_idx), .ld_data(sr_ld_data),
    .save_done, .restore_done
  );

  ctx_state_ram #(.DW(DW), .DEPTH(DEPTH), .MAW(MAW)) u_sram (
    .clk, .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
    .re(m_re), .raddr(m_raddr), .rdata(m_rdata)
  );

  assign sr_st_data = slot_st[sr_tgt];

  generate
    for (genvar k = 0; k < NUM_FN; k++) begin : g_slot
      ctx_fn_slot #(.DW(DW), .KIND(k % 4), .SW(SW), .IW(IW)) u_fn (
        .clk, .rst, .clr(swap_clr),
        .sel(run_on && (run_fn == FN_W'(k))),
        .in_valid(v1), .x(in_rdata),
        .ld_en(sr_ld_en && (sr_tgt == FN_W'(k))), .ld_idx(sr_ld_idx), .ld_data(sr_ld_data),
        .st_idx(sr_st_idx), .st_data(slot_st[k]),
        .y(slot_y[k]), .y_valid(slot_v[k])
      );
      assign gated_y[k] = slot_v[k] ? slot_y[k] : '0;
    end
  endgenerate

  always_comb begin
    mux_y = '0;
    for (int k = 0; k < NUM_FN; k++) mux_y = mux_y | gated_y[k];
  end
  assign mux_valid = |slot_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_on    <= 1'b0;
      run_fn    <= '0;
      loaded_q  <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      v1        <= 1'b0;
      in_en     <= 1'b0;
      in_addr   <= '0;
      out_en    <= 1'b0;
      out_we    <= 1'b0;
      out_addr  <= '0;
      out_wdata <= '0;
    end else begin
      v1     <= in_en;
      in_en  <= 1'b0;
      out_en <= 1'b0;
      out_we <= 1'b0;
      if (start_ok || rest_ok) loaded_q <= req_fn;
      if (start_ok) begin
        run_on <= 1'b1;
        run_fn <= req_fn;
        rd_cnt <= '0;
        wr_cnt <= '0;
      end else if (run_on) begin
        if (rd_cnt < len_q) begin
          in_en   <= 1'b1;
          in_addr <= src_q + rd_cnt[AW-1:0];
          rd_cnt  <= rd_cnt + LW'(1);
        end
        if (mux_valid) begin
          out_en    <= 1'b1;
          out_we    <= 1'b1;
          out_addr  <= dst_q + wr_cnt[AW-1:0];
          out_wdata <= mux_y;
          wr_cnt    <= wr_cnt + LW'(1);
          if (run_done) run_on <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctx_shell_chk.sv
module ctx_shell_chk (
  input logic clk,
  input logic rst,
  input logic in_en,
  input logic out_en,
  input logic run_on,
  input logic sr_busy,
  input logic run_done,
  input logic sr_ld_en
);
  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!in_en && !out_en)); // R1
  AST_READ_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    in_en |-> $past(run_on)); // R3
  AST_DONE_WITH_LAST_WRITE: assert property (@(posedge clk) disable iff (rst)
    run_done |=> out_en); // R3
  AST_WRITE_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    out_en |-> $past(run_on)); // R9
  AST_SR_EXCLUDES_RUN: assert property (@(posedge clk) disable iff (rst)
    sr_busy |-> !run_on); // R10
  AST_LOAD_WHILE_IDLE: assert property (@(posedge clk) disable iff (rst)
    sr_ld_en |-> !run_on); // R8
endmodule

bind accel_ctx_shell ctx_shell_chk u_chk (
  .clk(clk), .rst(rst), .in_en(in_en), .out_en(out_en), .run_on(run_on),
  .sr_busy(sr_busy), .run_done(run_done), .sr_ld_en(sr_ld_en)
);

// File: tb/accel_ctx_shell_tb.sv
module accel_ctx_shell_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_cs, bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        in_en, in_we, out_en, out_we;
  logic [9:0]  in_addr, out_addr;
  logic [15:0] in_rdata, out_wdata;

  always #10 clk = ~clk;

  accel_ctx_shell u_dut (
    .clk, .rst, .bus_cs, .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata,
    .in_en, .in_we, .in_addr, .in_rdata, .out_en, .out_we, .out_addr, .out_wdata
  );

  logic [15:0] imem [1024];
  logic [15:0] omem [1024];
  int          wr_seen = 0;
  int          in_we_seen = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  int          run_wr0;
  logic [15:0] m_acc [4], m_prev [4], s_acc [4], s_prev [4];
  int          m_loaded;

  always @(posedge clk) begin
    if (in_en) in_rdata <= imem[in_addr];
    if (in_we) in_we_seen++;
    if (out_en && out_we) begin
      omem[out_addr] = out_wdata;
      wr_seen++;
    end
  end

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_cs = 0; bus_rd = 0;
  endtask

  task automatic wait_idle;
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      bus_read(4'h5, s);
      if (!s[0]) return;
    end
  endtask

  task automatic model_step(input int fn, input logic [15:0] x, output logic [15:0] y);
    case (fn)
      0: begin m_acc[0] = m_acc[0] + x; y = m_acc[0] + m_prev[0]; m_prev[0] = x; end
      1: y = x + 16'h0101;
      2: y = x ^ 16'h5A5A;
      default: begin m_acc[3] = m_acc[3] + (x >> 1); y = m_acc[3] - m_prev[3]; m_prev[3] = x; end
    endcase
  endtask

  task automatic model_swap(input int fn);
    if (fn != m_loaded) begin
      for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_prev[k] = 0; end
      m_loaded = fn;
    end
  endtask

  task automatic start_run(input int fn, input int src, input int len, input int dst);
    bus_write(4'h1, 16'(len));
    bus_write(4'h2, 16'(src));
    bus_write(4'h3, 16'(dst));
    run_wr0 = wr_seen;
    bus_write(4'h0, 16'((fn << 2) | 1));
  endtask

  task automatic finish_run(input int fn, input int src, input int len, input int dst, input string req);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    logic [15:0] y;
    wait_idle();
    chk(wr_seen - run_wr0 == len, "R9", wr_seen - run_wr0, len, "write count");
    model_swap(fn);
    for (int i = 0; i < len; i++) begin
      model_step(fn, imem[10'(src + i)], y);
      if (omem[10'(dst + i)] !== y) begin
        if (bad == 0) begin first_act = int'(omem[10'(dst + i)]); first_exp = int'(y); end
        bad++;
      end
    end
    chk(bad == 0, req, first_act, first_exp, $sformatf("fn%0d samples", fn));
  endtask

  task automatic run_check(input int fn, input int src, input int len, input int dst, input string req);
    start_run(fn, src, len, dst);
    finish_run(fn, src, len, dst, req);
  endtask

  task automatic sr_request(input bit restore, input int fn);
    bus_write(4'h4, 16'((fn << 2) | (restore ? 2 : 1)));
    wait_idle();
  endtask

  task automatic t_reset;
    logic [15:0] d;
    bus_read(4'h5, d);
    chk(d == 16'h0, "R1", d, 0, "status after reset");
    bus_read(4'h1, d);
    chk(d == 16'h0, "R1", d, 0, "count after reset");
    chk(!in_en && !out_en, "R1", {in_en, out_en}, 0, "RAM enables after reset");
  endtask

  task automatic t_regs;
    logic [15:0] d;
    bus_write(4'h1, 16'h0455); bus_read(4'h1, d);
    chk(d == 16'h0455, "R2", d, 16'h0455, "count readback");
    bus_write(4'h2, 16'h02A7); bus_read(4'h2, d);
    chk(d == 16'h02A7, "R2", d, 16'h02A7, "source readback");
    bus_write(4'h3, 16'h0135); bus_read(4'h3, d);
    chk(d == 16'h0135, "R2", d, 16'h0135, "destination readback");
  endtask

  task automatic t_timing_comb;
    logic e1, e2, e3;
    logic [15:0] s;
    bus_write(4'h5, 0);
    start_run(1, 0, 4, 100);
    @(negedge clk); e1 = out_en;
    @(negedge clk); e2 = out_en;
    @(negedge clk); e3 = out_en;
    chk(!e1 && !e2 && e3, "R3", {e1, e2, e3}, 3'b001, "first write latency");
    finish_run(1, 0, 4, 100, "R4");
    bus_read(4'h5, s);
    chk(s[1] && !s[0], "R3", s, 16'h0002, "done set after run");
    chk(in_we_seen == 0, "R3", in_we_seen, 0, "input write enable");
  endtask

  task automatic t_save_restore(input int fn, input string req);
    logic [15:0] s;
    run_check(2, 50, 3, 900, "R4");
    run_check(fn, 0, 12, 300, "R5");
    bus_write(4'h5, 0);
    sr_request(0, fn);
    s_acc[fn] = m_acc[fn]; s_prev[fn] = m_prev[fn];
    bus_read(4'h5, s);
    chk(s[2] && !s[4], "R7", s, 16'h0004, "save complete");
    run_check(1, 20, 5, 400, "R6");
    sr_request(1, fn);
    model_swap(fn);
    m_acc[fn] = s_acc[fn]; m_prev[fn] = s_prev[fn];
    bus_read(4'h5, s);
    chk(s[3] && !s[4] && (s[6:5] == 2'(fn)), "R8", s, 16'(8 | (fn << 5)), "restore complete");
    run_check(fn, 12, 12, 312, req);
  endtask

  task automatic t_swap;
    run_check(0, 70, 6, 450, "R5");
    run_check(0, 76, 6, 456, "R5");
    run_check(2, 5, 2, 470, "R4");
    run_check(0, 90, 6, 480, "R6");
  endtask

  task automatic t_refuse;
    logic [15:0] s;
    run_check(0, 40, 6, 500, "R5");
    sr_request(0, 0);
    s_acc[0] = m_acc[0]; s_prev[0] = m_prev[0];
    bus_write(4'h5, 0);
    start_run(0, 100, 64, 600);
    bus_write(4'h4, 16'h0001);
    bus_write(4'h0, 16'h0005);
    finish_run(0, 100, 64, 600, "R10");
    bus_read(4'h5, s);
    chk(s[4] && !s[2] && s[6:5] == 0, "R10", s, 16'h0012, "busy refusals");
    sr_request(1, 0);
    m_acc[0] = s_acc[0]; m_prev[0] = s_prev[0];
    run_check(0, 200, 8, 700, "R10");
    bus_write(4'h5, 0);
    bus_write(4'h1, 0);
    run_wr0 = wr_seen;
    bus_write(4'h0, 16'h0009);
    repeat (6) @(negedge clk);
    bus_read(4'h5, s);
    chk(wr_seen == run_wr0 && s[4] && !s[0], "R10", s, 16'h0010, "zero count start");
  endtask

  task automatic t_bad_target;
    logic [15:0] s;
    bus_write(4'h5, 0);
    sr_request(0, 1);
    bus_read(4'h5, s);
    chk(s[4] && !s[2], "R11", s, 16'h0010, "save of stateless fn");
    bus_write(4'h5, 0);
    sr_request(0, 3);
    bus_read(4'h5, s);
    chk(s[4] && !s[2], "R11", s, 16'h0010, "save of unloaded fn");
    bus_write(4'h5, 0);
    sr_request(1, 2);
    bus_read(4'h5, s);
    chk(s[4] && !s[3] && s[6:5] == 2'd0, "R11", s, 16'h0010, "restore of stateless fn");
  endtask

  task automatic t_clear;
    logic [15:0] s;
    bus_write(4'h5, 16'hFFFF);
    bus_read(4'h5, s);
    chk(s[4:0] == 0 && s[6:5] == 2'd0, "R12", s, 0, "status clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      imem[i] = 16'((i * 40503 + 7) ^ (i << 5));
      omem[i] = 16'h0;
    end
    for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_prev[k] = 0; end
    m_loaded = 0;
    rst = 1; bus_cs = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_timing_comb();
    run_check(2, 10, 5, 120, "R4");
    t_save_restore(0, "R8");
    t_save_restore(3, "R8");
    t_swap();
    t_refuse();
    t_bad_target();
    t_clear();
    report();
    $finish;
  end
endmodule